// File: doc/BRIEF.md
# External Bus Strobe Generator

This block drives the two timing strobes of an 8-bit microcontroller's multiplexed external memory bus. The first is an active-high address latch strobe. The second is an active-low program read strobe. Both come from the oscillator clock, which is grouped into machine cycles. A machine cycle has six states of two clocks each, so it lasts twelve clocks. The latch strobe pulses twice in every machine cycle, which gives a steady clock-derived output even when no external memory is in use. The program read strobe follows each latch pulse while code is fetched from external program memory.

The core supplies four inputs. The first is a level that says whether code runs from external memory. The second is a per-cycle flag marking a machine cycle that moves data to or from external data memory. The third is a flag marking a table-read or external-move instruction. The fourth is the latch-disable control bit. The block samples all four once, on the clock edge that begins a machine cycle, and uses them for that whole cycle.

In an external data cycle the second latch pulse is dropped and the read strobe is silent. When the disable bit is set and code runs from internal memory, the latch strobe pulses only for table-read or external-move instructions. While the strobe is held off, the output stays low and the board pull-up gives the idle pin level.

Top module: `bus_strobe_gen`

## Requirements
- R1: A machine cycle lasts 12 clocks. The first cycle begins at the first rising edge with rst_n high. Latch pulses last one clock and fall only at clock offsets 0 and 6 of a cycle.
- R2: When the cycle has no external data access and the disable bit is clear, the latch strobe pulses twice per cycle (offsets 0 and 6), whether the external-execution flag is set or not.
- R3: In a cycle with xdata_cyc_i set, the pulse at offset 6 is omitted and the pulse at offset 0 is kept.
- R4: With latch_off_i set, ext_exec_i clear and xmove_inst_i clear, addr_latch_o stays low for the whole cycle.
- R5: With latch_off_i set and xmove_inst_i set, the latch strobe behaves as in R2 and R3.
- R6: latch_off_i has no effect while ext_exec_i is set.
- R7: With ext_exec_i set and xdata_cyc_i clear, prog_rd_n_o is low at offsets 1 to 3 and 7 to 9 and high elsewhere. With ext_exec_i clear, it stays high.
- R8: With ext_exec_i set and xdata_cyc_i set, prog_rd_n_o stays high for the whole cycle.
- R9: All four flags are sampled at the edge that starts offset 0. Changing them later in the cycle does not change that cycle's strobes.
- R10: On the first edge with rst_n low, addr_latch_o goes low and prog_rd_n_o goes high. After release, the cycle count restarts at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_exec_i | input | 1 | Code is being fetched from external program memory |
| xdata_cyc_i | input | 1 | This machine cycle accesses external data memory |
| xmove_inst_i | input | 1 | Current instruction is a table read or external move |
| latch_off_i | input | 1 | Latch-disable control bit |
| addr_latch_o | output | 1 | Address latch strobe, active high |
| prog_rd_n_o | output | 1 | Program read strobe, active low |

## Verification
The bench builds the block with its default parameters: two clocks per state, six states, latch pulses in states 0 and 3, and a three-clock read window. Under these values every clock offset of the 12-clock cycle can be checked as a bit of a 12-bit pattern. All combinations of the external-execution, external-data and disable flags are covered, with and without a table-read instruction. Flags that change mid-cycle and a reset taken in the middle of a cycle while the read strobe is low are also within reach.

// File: rtl/bstrobe_pkg.sv
// Package: shared types for the bus strobe generator.
// Assumes: one context record is captured per machine cycle.
package bstrobe_pkg;

    // Per-cycle control context, captured at the start of each machine cycle
    typedef struct packed {
        logic ext_exec;
        logic xdata;
        logic xmove;
        logic latch_off;
    } cyc_ctx_t;

endpackage

// File: rtl/bstrobe_timer.sv
// Module: machine-cycle clock counter.
// Counts clock offsets 0 .. CLKS_PER_CYCLE-1.
// Exposes the next offset, so that downstream registers line up with it.
// Assumes: reset parks the counter on the last offset, so the first active
// edge enters offset 0.
module bstrobe_timer #(
    parameter int unsigned CLKS_PER_CYCLE = 12,
    localparam int unsigned PW = $clog2(CLKS_PER_CYCLE)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase_nxt_o,
    output logic          wrap_nxt_o
);
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_CYCLE - 1);

    logic [PW-1:0] phase_q;

    // Next offset: wrap after the last clock of the cycle
    always_comb begin
        phase_nxt_o = (phase_q == LAST) ? '0 : phase_q + 1'b1;
        wrap_nxt_o  = (phase_q == LAST);
    end

    // Offset register, parked at the last offset during reset
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= LAST;
        else        phase_q <= phase_nxt_o;
    end
endmodule

// File: rtl/bstrobe_ctx.sv
// Module: per-cycle context capture.
// Latches the four control flags on the edge that starts a machine cycle.
// Holds them until the next cycle starts.
// Assumes: wrap_nxt_i is high exactly on the edge entering offset 0.
module bstrobe_ctx
    import bstrobe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wrap_nxt_i,
    input  logic     ext_exec_i,
    input  logic     xdata_cyc_i,
    input  logic     xmove_inst_i,
    input  logic     latch_off_i,
    output cyc_ctx_t ctx_nxt_o
);
    cyc_ctx_t ctx_q;
    cyc_ctx_t ctx_in;

    // Pack the live inputs; select them only at a cycle boundary
    always_comb begin
        ctx_in.ext_exec  = ext_exec_i;
        ctx_in.xdata     = xdata_cyc_i;
        ctx_in.xmove     = xmove_inst_i;
        ctx_in.latch_off = latch_off_i;
        ctx_nxt_o        = wrap_nxt_i ? ctx_in : ctx_q;
    end

    // Context register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_nxt_o;
    end
endmodule

// File: rtl/bstrobe_decode.sv
// Module: strobe decode and output registers.
// Two latch slots sit at fixed states. The second slot is dropped in
// external data cycles. A read window follows each slot.
// Outputs are registered from the next offset and context, so they change
// on the edge that enters each offset.
// Assumes: LATCH_STATE_A < LATCH_STATE_B and windows fit inside the cycle.
module bstrobe_decode
    import bstrobe_pkg::*;
#(
    parameter int unsigned CLKS_PER_STATE   = 2,
    parameter int unsigned STATES_PER_CYCLE = 6,
    parameter int unsigned LATCH_STATE_A    = 0,
    parameter int unsigned LATCH_STATE_B    = 3,
    parameter int unsigned READ_LOW_CLKS    = 3,
    localparam int unsigned CLKS_PER_CYCLE  = CLKS_PER_STATE * STATES_PER_CYCLE,
    localparam int unsigned PW              = $clog2(CLKS_PER_CYCLE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase_nxt_i,
    input  cyc_ctx_t      ctx_nxt_i,
    output logic          latch_o,
    output logic          rd_n_o
);
    localparam int unsigned NSLOT = 2;
    localparam int unsigned SLOT_POS [NSLOT] = '{LATCH_STATE_A * CLKS_PER_STATE,
                                                 LATCH_STATE_B * CLKS_PER_STATE};

    logic latch_nxt;
    logic rd_nxt;
    logic gate_open;
    logic fetch_ok;

    // Decide, for the coming offset, whether each strobe is active
    always_comb begin
        int unsigned ph;
        ph        = 32'(phase_nxt_i);
        gate_open = ctx_nxt_i.ext_exec | ~ctx_nxt_i.latch_off | ctx_nxt_i.xmove;
        fetch_ok  = ctx_nxt_i.ext_exec & ~ctx_nxt_i.xdata;
        latch_nxt = 1'b0;
        rd_nxt    = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (ph == SLOT_POS[s] && gate_open && (s == 0 || !ctx_nxt_i.xdata))
                latch_nxt = 1'b1;
            if (ph > SLOT_POS[s] && ph <= SLOT_POS[s] + READ_LOW_CLKS && fetch_ok)
                rd_nxt = 1'b1;
        end
    end

    // Output registers with idle levels in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o <= 1'b0;
            rd_n_o  <= 1'b1;
        end else begin
            latch_o <= latch_nxt;
            rd_n_o  <= ~rd_nxt;
        end
    end
endmodule

// File: rtl/bus_strobe_gen.sv
// Module: external bus strobe generator (top).
// Chains the cycle counter, the context capture and the strobe decode.
// Assumes: the control flags are stable around the edge that starts a cycle.
module bus_strobe_gen
    import bstrobe_pkg::*;
#(
    parameter int unsigned CLKS_PER_STATE   = 2,
    parameter int unsigned STATES_PER_CYCLE = 6,
    parameter int unsigned LATCH_STATE_A    = 0,
    parameter int unsigned LATCH_STATE_B    = 3,
    parameter int unsigned READ_LOW_CLKS    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_exec_i,
    input  logic xdata_cyc_i,
    input  logic xmove_inst_i,
    input  logic latch_off_i,
    output logic addr_latch_o,
    output logic prog_rd_n_o
);
    localparam int unsigned CLKS_PER_CYCLE = CLKS_PER_STATE * STATES_PER_CYCLE;
    localparam int unsigned PW = $clog2(CLKS_PER_CYCLE);

    logic [PW-1:0] phase_nxt;
    logic          wrap_nxt;
    cyc_ctx_t      ctx_nxt;

    bstrobe_timer #(.CLKS_PER_CYCLE(CLKS_PER_CYCLE)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_nxt_o(phase_nxt),
        .wrap_nxt_o (wrap_nxt)
    );

    bstrobe_ctx u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wrap_nxt_i  (wrap_nxt),
        .ext_exec_i  (ext_exec_i),
        .xdata_cyc_i (xdata_cyc_i),
        .xmove_inst_i(xmove_inst_i),
        .latch_off_i (latch_off_i),
        .ctx_nxt_o   (ctx_nxt)
    );

    bstrobe_decode #(
        .CLKS_PER_STATE  (CLKS_PER_STATE),
        .STATES_PER_CYCLE(STATES_PER_CYCLE),
        .LATCH_STATE_A   (LATCH_STATE_A),
        .LATCH_STATE_B   (LATCH_STATE_B),
        .READ_LOW_CLKS   (READ_LOW_CLKS)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_nxt_i(phase_nxt),
        .ctx_nxt_i  (ctx_nxt),
        .latch_o    (addr_latch_o),
        .rd_n_o     (prog_rd_n_o)
    );
endmodule

// File: rtl/bus_strobe_gen_chk.sv
// Checker: timing properties of the strobe outputs, bound to the top.
// Keeps its own offset counter from reset release.
module bus_strobe_gen_chk #(
    parameter int unsigned CLKS_PER_STATE   = 2,
    parameter int unsigned STATES_PER_CYCLE = 6,
    parameter int unsigned LATCH_STATE_A    = 0,
    parameter int unsigned LATCH_STATE_B    = 3,
    parameter int unsigned READ_LOW_CLKS    = 3
) (
    input logic clk,
    input logic rst_n,
    input logic addr_latch_o,
    input logic prog_rd_n_o
);
    localparam int unsigned NCLK = CLKS_PER_STATE * STATES_PER_CYCLE;
    localparam int unsigned POS_A = LATCH_STATE_A * CLKS_PER_STATE;
    localparam int unsigned POS_B = LATCH_STATE_B * CLKS_PER_STATE;

    int unsigned ofs;

    // Offset counter: offset of the clock period after each edge
    always_ff @(posedge clk) begin
        if (!rst_n) ofs <= NCLK - 1;
        else        ofs <= (ofs == NCLK - 1) ? 0 : ofs + 1;
    end

    logic at_slot;
    logic in_window;
    assign at_slot   = (ofs == POS_A) || (ofs == POS_B);
    assign in_window = (ofs > POS_A && ofs <= POS_A + READ_LOW_CLKS) ||
                       (ofs > POS_B && ofs <= POS_B + READ_LOW_CLKS);

    // R1: latch pulses last one clock
    p_latch_one_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch_o |=> !addr_latch_o);

    // R1: latch pulses appear only at slot offsets
    p_latch_at_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_latch_o |-> at_slot);

    // R7: read strobe is low only inside a read window
    p_read_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_rd_n_o |-> in_window);

    // R7: read strobe never overlaps a latch pulse
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_latch_o && !prog_rd_n_o));

    // R7: read strobe starts right after a latch slot
    p_read_after_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_rd_n_o) |-> (ofs == POS_A + 1 || ofs == POS_B + 1));
endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(
    .CLKS_PER_STATE  (CLKS_PER_STATE),
    .STATES_PER_CYCLE(STATES_PER_CYCLE),
    .LATCH_STATE_A   (LATCH_STATE_A),
    .LATCH_STATE_B   (LATCH_STATE_B),
    .READ_LOW_CLKS   (READ_LOW_CLKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_latch_o(addr_latch_o),
    .prog_rd_n_o (prog_rd_n_o)
);

// File: tb/bus_strobe_gen_bench.sv
`timescale 1ns/1ps
module bus_strobe_gen_bench;
    localparam int NCLK = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_exec = 1'b0, xdata = 1'b0, xmove = 1'b0, loff = 1'b0;
    logic addr_latch, prog_rd_n;

    int tests = 0;
    int fails = 0;
    bit go = 1'b0;
    bit mon_done = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        logic [NCLK-1:0] ale;
        logic [NCLK-1:0] rdn;
        string           tag;
    } exp_t;
    exp_t q[$];
    int n_cycles = 0;

    always #4 clk = ~clk;

    bus_strobe_gen u_bus_strobe_gen (
        .clk(clk), .rst_n(rst_n),
        .ext_exec_i(ext_exec), .xdata_cyc_i(xdata),
        .xmove_inst_i(xmove), .latch_off_i(loff),
        .addr_latch_o(addr_latch), .prog_rd_n_o(prog_rd_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [NCLK-1:0] act, input logic [NCLK-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Driver: apply one machine cycle of flags and push the expected patterns
    task automatic run_cycle(input logic e, input logic x, input logic m,
                             input logic o, input bit glitch, input string tag);
        exp_t it;
        logic gate;
        ext_exec = e; xdata = x; xmove = m; loff = o;
        gate = e | ~o | m;
        it.ale = '0;
        it.rdn = '1;
        if (gate) it.ale[0] = 1'b1;
        if (gate && !x) it.ale[6] = 1'b1;
        if (e && !x) begin
            it.rdn[1] = 0; it.rdn[2] = 0; it.rdn[3] = 0;
            it.rdn[7] = 0; it.rdn[8] = 0; it.rdn[9] = 0;
        end
        it.tag = tag;
        q.push_back(it);
        repeat (6) @(negedge clk);
        if (glitch) begin
            ext_exec = ~e; xdata = ~x; xmove = ~m; loff = ~o;
        end
        repeat (6) @(negedge clk);
    endtask

    // Monitor: collect 12 samples per cycle and compare with the queue head
    initial begin
        wait (go);
        while (!mon_done) begin
            logic [NCLK-1:0] ga, gr;
            exp_t it;
            for (int k = 0; k < NCLK; k++) begin
                @(negedge clk);
                ga[k] = addr_latch;
                gr[k] = prog_rd_n;
            end
            if (q.size() == 0) begin
                check(1'b0, "R1", "unexpected cycle", ga, '0);
            end else begin
                it = q.pop_front();
                check(ga == it.ale, it.tag, "latch pattern", ga, it.ale);
                check(gr == it.rdn, it.tag, "read pattern", gr, it.rdn);
            end
            n_cycles++;
            if (n_cycles == 13) mon_done = 1'b1;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: idle levels in reset
        check(addr_latch == 1'b0 && prog_rd_n == 1'b1, "R10", "reset idle",
              {addr_latch, prog_rd_n}, 2'b01);
        rst_n = 1'b1;
        go = 1'b1;
        run_cycle(0, 0, 0, 0, 0, "R1");
        run_cycle(1, 0, 0, 0, 0, "R7");
        run_cycle(0, 1, 0, 0, 0, "R3");
        run_cycle(1, 1, 0, 0, 0, "R8");
        run_cycle(0, 0, 0, 1, 0, "R4");
        run_cycle(0, 1, 0, 1, 0, "R4");
        run_cycle(0, 0, 1, 1, 0, "R5");
        run_cycle(0, 1, 1, 1, 0, "R5");
        run_cycle(1, 0, 0, 1, 0, "R6");
        run_cycle(1, 1, 0, 1, 0, "R6");
        run_cycle(1, 0, 0, 0, 1, "R9");
        run_cycle(0, 0, 0, 1, 1, "R9");
        run_cycle(0, 0, 0, 0, 0, "R2");
        wait (mon_done);
        // R10: reset in mid-cycle while the read strobe is low
        ext_exec = 1; xdata = 0; xmove = 0; loff = 0;
        repeat (2) @(negedge clk);
        check(prog_rd_n == 1'b0, "R10", "read low before reset", {1'b0, prog_rd_n}, 2'b00);
        rst_n = 1'b0;
        @(negedge clk);
        check(addr_latch == 1'b0 && prog_rd_n == 1'b1, "R10", "mid-cycle reset idle",
              {addr_latch, prog_rd_n}, 2'b01);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_latch == 1'b1 && prog_rd_n == 1'b1, "R10", "restart offset 0",
              {addr_latch, prog_rd_n}, 2'b11);
        @(negedge clk);
        check(addr_latch == 1'b0 && prog_rd_n == 1'b0, "R10", "restart offset 1",
              {addr_latch, prog_rd_n}, 2'b00);
        finish_run();
    end
endmodule